// File: doc/BRIEF.md
# Signed Integer to Single-Precision Converter

This block turns a 32-bit two's-complement integer into a single-precision binary floating-point word. A 3-bit code selects the rounding direction. Any bit shifted out below the 24-bit significand raises the inexact flag. Both the sign and the magnitude come from the operand. The leading one is moved to the top of the word, and the exponent is set from the shift distance. Guard and sticky bits then decide rounding, and a carry out of rounding moves up into the exponent.

Two inputs skip the normalising path. Zero gives positive zero. The most negative integer gives an exact power of two with sign 1. A rounding code outside the five defined ones is flagged as illegal, and the result is then forced to zero. Each accepted operand produces one result a fixed two cycles later. The block accepts a new operand every cycle.

Top module: `int_to_single_cvt`

## Requirements
- R1: An operand of 0 gives out_float = 0x00000000 and out_flags = 0, for every legal rounding code.
- R2: An operand of 0x80000000 gives out_float = 0xCF000000 (sign 1, biased exponent 0x9E, fraction 0) with the inexact flag clear.
- R3: An operand whose magnitude is below 2^24 converts exactly and the inexact flag (out_flags bit 0) stays 0.
- R4: Rounding code 3'b000 rounds to the nearest value and breaks a tie toward an even significand.
- R5: Rounding code 3'b001 truncates toward zero.
- R6: Rounding code 3'b010 rounds toward minus infinity and rounding code 3'b011 rounds toward plus infinity, so the direction taken depends on the operand's sign.
- R7: Rounding code 3'b100 rounds to the nearest value and breaks a tie away from zero.
- R8: When rounding carries out of the 24-bit significand, the biased exponent rises by one and the fraction becomes 0. For example, 0x7FFFFFFF rounded to nearest gives 0x4F000000.
- R9: out_flags bit 0 (inexact) is 1 exactly when the bits discarded below the significand are nonzero. Bits 4:1 (invalid, divide-by-zero, overflow, underflow) are always 0.
- R10: Rounding codes 3'b101, 3'b110 and 3'b111 set out_illegal to 1, with out_float = 0 and out_flags = 0. Legal codes give out_illegal = 0.
- R11: out_valid rises exactly two clock cycles after in_valid, once for each accepted operand, and it is 0 while rst is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_int | input | 32 | Two's-complement integer operand |
| in_rm | input | 3 | Rounding code |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_float | output | 32 | Single-precision result |
| out_flags | output | 5 | {invalid, div-by-zero, overflow, underflow, inexact} |
| out_illegal | output | 1 | Rounding code was not one of the five legal codes |

## Verification
The assertions take for granted that in_int and in_rm hold known values whenever in_valid is high. They also assume that in_valid is held low during reset, so that the values recalled two cycles back always belong to a real operand. The bench drives every input on the falling clock edge and keeps in_valid at 0 throughout reset. It drives zero on idle operands, and it draws random rounding codes only from the legal range. The illegal codes are driven only as explicit directed cases.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
    localparam int INT_W   = 32;
    localparam int FP_W    = 32;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int BIAS    = 127;
    localparam int LZ_W    = $clog2(INT_W) + 1;
    localparam int FLAG_W  = 5;
    localparam int FLAG_NX = 0;
    // exponent of a value whose leading one sits in the top operand bit
    localparam int EXP_TOP = BIAS + INT_W - 1;

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'b000,
        RM_ZERO      = 3'b001,
        RM_DOWN      = 3'b010,
        RM_UP        = 3'b011,
        RM_NEAR_MAX  = 3'b100
    } rmode_e;

    typedef struct packed {
        logic             illegal;
        rmode_e           mode;
        logic             sign;
        logic             is_zero;
        logic             is_min;
        logic [INT_W-1:0] mag;
    } stage_t;

    function automatic logic [LZ_W-1:0] lead_zeros(logic [INT_W-1:0] v);
        logic [LZ_W-1:0] n;
        logic            hit;
        n   = '0;
        hit = 1'b0;
        for (int i = INT_W - 1; i >= 0; i--) begin
            if (!hit) begin
                if (v[i]) hit = 1'b1;
                else      n   = n + LZ_W'(1);
            end
        end
        return n;
    endfunction
endpackage

// File: rtl/i2f_magnitude.sv
module i2f_magnitude
    import i2f_pkg::*;
(
    input  logic [INT_W-1:0] op,
    input  logic [2:0]       rm_code,
    output stage_t           stage
);
    logic bad_code;

    always_comb begin
        bad_code      = (rm_code > 3'd4);
        stage.illegal = bad_code;
        stage.mode    = bad_code ? RM_NEAR_EVEN : rmode_e'(rm_code);
        stage.sign    = op[INT_W-1];
        stage.is_zero = (op == '0);
        stage.is_min  = op[INT_W-1] && (op[INT_W-2:0] == '0);
        stage.mag     = op[INT_W-1] ? (~op + INT_W'(1)) : op;
    end
endmodule

// File: rtl/i2f_normalize.sv
module i2f_normalize
    import i2f_pkg::*;
(
    input  logic [INT_W-1:0] mag,
    output logic [INT_W-1:0] norm,
    output logic [LZ_W-1:0]  shift
);
    always_comb begin
        shift = lead_zeros(mag);
        norm  = mag << shift;
    end
endmodule

// File: rtl/i2f_round.sv
module i2f_round
    import i2f_pkg::*;
(
    input  logic             sign,
    input  rmode_e           mode,
    input  logic [INT_W-1:0] norm,
    input  logic [LZ_W-1:0]  shift,
    output logic [FP_W-1:0]  result,
    output logic             inexact
);
    localparam int GRD = INT_W - SIG_W - 1;

    logic [SIG_W-1:0] sig;
    logic             guard;
    logic             sticky;
    logic             lost;
    logic             inc;
    logic [SIG_W:0]   sum;
    logic [EXP_W-1:0] exp_less1;
    logic [FP_W-2:0]  body;

    always_comb begin
        sig    = norm[INT_W-1 -: SIG_W];
        guard  = norm[GRD];
        sticky = |norm[GRD-1:0];
        lost   = guard | sticky;
        case (mode)
            RM_NEAR_EVEN: inc = guard & (sticky | sig[0]);
            RM_ZERO:      inc = 1'b0;
            RM_DOWN:      inc = lost & sign;
            RM_UP:        inc = lost & ~sign;
            RM_NEAR_MAX:  inc = guard;
            default:      inc = 1'b0;
        endcase
        sum = {1'b0, sig} + {{SIG_W{1'b0}}, inc};
        // the hidden one of sum lands in the exponent field; a rounding
        // carry (sum = 2^24) adds one more and leaves the fraction zero
        exp_less1 = EXP_W'(EXP_TOP - 1) - EXP_W'(shift);
        body      = {exp_less1, {FRAC_W{1'b0}}} + (FP_W-1)'(sum);
        result    = {sign, body};
        inexact   = lost;
    end
endmodule

// File: rtl/int_to_single_cvt.sv
module int_to_single_cvt
    import i2f_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INT_W-1:0]  in_int,
    input  logic [2:0]        in_rm,
    output logic              out_valid,
    output logic [FP_W-1:0]   out_float,
    output logic [FLAG_W-1:0] out_flags,
    output logic              out_illegal
);
    localparam logic [FP_W-1:0] MIN_RESULT =
        {1'b1, EXP_W'(EXP_TOP), {FRAC_W{1'b0}}};

    stage_t           s1_d;
    stage_t           s1_q;
    logic             s1_vld;
    logic [INT_W-1:0] norm_mag;
    logic [LZ_W-1:0]  lz;
    logic [FP_W-1:0]  rnd_res;
    logic             rnd_nx;
    logic [FP_W-1:0]  res_d;
    logic             nx_d;

    i2f_magnitude u_mag (
        .op      (in_int),
        .rm_code (in_rm),
        .stage   (s1_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld <= 1'b0;
            s1_q   <= '0;
        end else begin
            s1_vld <= in_valid;
            if (in_valid) s1_q <= s1_d;
        end
    end

    i2f_normalize u_norm (
        .mag   (s1_q.mag),
        .norm  (norm_mag),
        .shift (lz)
    );

    i2f_round u_rnd (
        .sign    (s1_q.sign),
        .mode    (s1_q.mode),
        .norm    (norm_mag),
        .shift   (lz),
        .result  (rnd_res),
        .inexact (rnd_nx)
    );

    always_comb begin
        if (s1_q.illegal || s1_q.is_zero) begin
            res_d = '0;
            nx_d  = 1'b0;
        end else if (s1_q.is_min) begin
            res_d = MIN_RESULT;
            nx_d  = 1'b0;
        end else begin
            res_d = rnd_res;
            nx_d  = rnd_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_float   <= '0;
            out_flags   <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= s1_vld;
            if (s1_vld) begin
                out_float          <= res_d;
                out_flags          <= '0;
                out_flags[FLAG_NX] <= nx_d;
                out_illegal        <= s1_q.illegal;
            end
        end
    end
endmodule

// File: rtl/int_to_single_cvt_chk.sv
module int_to_single_cvt_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_int,
    input logic [2:0]  in_rm,
    input logic        out_valid,
    input logic [31:0] out_float,
    input logic [4:0]  out_flags,
    input logic        out_illegal
);
    logic [1:0] age;
    logic       ready;

    always_ff @(posedge clk) begin
        if (rst)              age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end
    assign ready = (age >= 2'd2);

    // R11
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (out_valid == $past(in_valid, 2)));

    // R10
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_float == 32'h0 && out_flags == 5'h0));

    // R10
    illegal_decode_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && out_valid) |-> (out_illegal == ($past(in_rm, 2) > 3'd4)));

    // R9
    flags_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_flags[4:1] == 4'h0));

    // R1
    zero_result_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && out_valid && $past(in_int, 2) == 32'h0)
        |-> (out_float == 32'h0 && out_flags == 5'h0));

    // R2
    most_neg_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && out_valid && !out_illegal && $past(in_int, 2) == 32'h8000_0000)
        |-> (out_float == 32'hCF00_0000 && !out_flags[0]));

    // R3
    exact_small_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && out_valid &&
         ($past(in_int, 2) < 32'h0100_0000 || $past(in_int, 2) >= 32'hFF00_0000))
        |-> !out_flags[0]);
endmodule

bind int_to_single_cvt int_to_single_cvt_chk chk_i (.*);

// File: tb/int_to_single_cvt_tb_top.sv
module int_to_single_cvt_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_int = '0;
    logic [2:0]  in_rm = '0;
    logic        out_valid;
    logic [31:0] out_float;
    logic [4:0]  out_flags;
    logic        out_illegal;

    int tests  = 0;
    int failed = 0;
    logic [37:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    int_to_single_cvt dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_int(in_int),
        .in_rm(in_rm), .out_valid(out_valid), .out_float(out_float),
        .out_flags(out_flags), .out_illegal(out_illegal)
    );

    // reference: {illegal, flags[4:0], float[31:0]}
    function automatic logic [37:0] model(logic [31:0] v, logic [2:0] rm);
        longint m, q, rem, half;
        int p, sh;
        logic s, inc, nx;
        logic [7:0] e;
        if (rm > 3'd4) return {1'b1, 37'h0};
        if (v == 32'h0) return 38'h0;
        s = v[31];
        m = s ? -longint'($signed(v)) : longint'(v);
        p = 0;
        for (int i = 0; i < 33; i++) if (m[i]) p = i;
        inc = 1'b0;
        nx  = 1'b0;
        if (p <= 23) begin
            q = m << (23 - p);
        end else begin
            sh   = p - 23;
            q    = m >> sh;
            rem  = m & ((longint'(1) << sh) - 1);
            half = longint'(1) << (sh - 1);
            nx   = (rem != 0);
            case (rm)
                3'd0: inc = (rem > half) || (rem == half && q[0]);
                3'd1: inc = 1'b0;
                3'd2: inc = nx && s;
                3'd3: inc = nx && !s;
                default: inc = (rem >= half);
            endcase
        end
        q = q + longint'(inc);
        if (q == (longint'(1) << 24)) begin
            q = longint'(1) << 23;
            p = p + 1;
        end
        e = 8'(127 + p);
        return {1'b0, 4'h0, nx, s, e, q[22:0]};
    endfunction

    task automatic send(logic [31:0] v, logic [2:0] rm, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_int   = v;
        in_rm    = rm;
        exp_q.push_back(model(v, rm));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_int   = '0;
        in_rm    = '0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            logic [37:0] got, expv;
            string t;
            got = {out_illegal, out_flags, out_float};
            tests++;
            if (exp_q.size() == 0) begin
                failed++;
                $display("FAIL R11 unexpected out_valid: actual %h expected none", got);
            end else begin
                expv = exp_q.pop_front();
                t    = tag_q.pop_front();
                if (got !== expv) begin
                    failed++;
                    $display("FAIL %s: actual %h expected %h", t, got, expv);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        failed++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        tests++;
        if (out_valid !== 1'b0 || out_float !== 32'h0) begin
            failed++;
            $display("FAIL R11 reset: actual %b/%h expected 0/0", out_valid, out_float);
        end
        rst = 1'b0;
        idle();
        // latency: one operand, check out_valid edge timing
        send(32'd5, 3'd0, "R3 small +5");
        idle();
        tests++;
        if (out_valid !== 1'b0) begin
            failed++;
            $display("FAIL R11 early valid: actual %b expected 0", out_valid);
        end
        idle();
        repeat (3) idle();
        for (int r = 0; r < 5; r++) begin
            send(32'h0, 3'(r), "R1 zero");
            send(32'h1, 3'(r), "R3 plus one");
            send(32'hFFFF_FFFF, 3'(r), "R3 minus one");
            send(32'h8000_0000, 3'(r), "R2 most negative");
            send(32'h7FFF_FFFF, 3'(r), "R8 max positive carry");
            send(32'h0100_0001, 3'(r), "R9 tie +(2^24+1)");
            send(32'hFEFF_FFFF, 3'(r), "R9 tie -(2^24+1)");
            send(32'h0100_0000, 3'(r), "R3 exact 2^24");
            send(32'h00FF_FFFF, 3'(r), "R3 2^24-1");
            send(32'hFF00_0001, 3'(r), "R3 -(2^24-1)");
            send(32'h0100_0003, 3'(r), "R4 R5 R7 tie odd");
            send(32'h0123_4567, 3'(r), "R6 positive direction");
            send(32'hFEDC_BA99, 3'(r), "R6 negative direction");
            send(32'h01FF_FFFF, 3'(r), "R8 carry mid range");
        end
        send(32'h0000_0007, 3'd5, "R10 code 101");
        send(32'h7FFF_FFFF, 3'd6, "R10 code 110");
        send(32'h8000_0001, 3'd7, "R10 code 111");
        idle();
        for (int k = 0; k < 400; k++) begin
            logic [31:0] rv;
            rv = $urandom;
            if (k % 3 == 1) rv = rv >> (k % 31);
            send(rv, 3'($urandom_range(4, 0)), "R4 R5 R6 R7 R9 random");
            if (k % 7 == 0) idle();
        end
        idle();
        repeat (6) @(negedge clk);
        tests++;
        if (exp_q.size() != 0) begin
            failed++;
            $display("FAIL R11 missing results: actual %0d pending expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule